// File: doc/BRIEF.md
# Compare-and-Splice Stream Matcher

After an interruption in an audio stream, the producer re-reads material that partly overlaps what was already buffered. This block finds the point where the re-read stream lines up with the buffered data, so that writing can resume just past the last valid data. It is given the three left/right sample pairs that came last before the stream stopped. After a start command it watches the incoming 16-bit samples and raises a one-clock connect pulse when the chosen splice policy is met.

Three policies are available. The first needs all three pairs to match. The second needs any two of the three pairs to match. The third does no comparison and connects after a fixed number of words. A level input switches the comparison to the upper 12 bits of each word. The first compare start after reset waits out a short preparation interval. Later starts skip that interval.

Top module: `splice_matcher`

## Requirements
- R1: After reset, `busy` and `connect` are low and the block holds no completed preparation.
- R2: A command with `cmd_mode` 2'b11 (all pairs), 2'b10 (two of three) or 2'b01 (direct) makes `busy` high in the next cycle. Mode 2'b00 (stop) makes `busy` low in the next cycle with no connect, and has no effect when the block is idle.
- R3: After the first all-pairs or two-of-three start since reset, the first PREP_WORDS strobes (default 5) are consumed without comparison. Any later start skips this interval.
- R4: The compare window starts with a left-channel word (`smp_right` = 0). Right-channel words that arrive before that are ignored.
- R5: Reference word i sits at `ref_words[16*i+15:16*i]`. Index 0 is the oldest left word, index 1 the oldest right word, and so on. Pair k is words 2k and 2k+1. In all-pairs mode, connect fires on a right-channel strobe when the last three received pairs equal pairs 0, 1 and 2.
- R6: In two-of-three mode, connect fires when at least two of the three pairs match in position.
- R7: On a mismatch the window slides by one pair. A match that comes later is found without a new command.
- R8: In direct mode, connect fires on the third strobe after the command, whatever the sample data.
- R9: While `cmp12` is high, bits 3:0 of each word are left out of the comparison. The level is sampled at each evaluation, so a change made mid-sequence applies from then on.
- R10: `connect` is high for exactly one cycle, in the cycle after the clock edge that samples the deciding strobe. `busy` is low in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_mode | input | 2 | 11 all pairs, 10 two of three, 01 direct, 00 stop |
| cmp12 | input | 1 | Compare only bits 15:4 |
| smp_valid | input | 1 | Sample strobe |
| smp_right | input | 1 | Channel of the sample: 0 left, 1 right |
| smp_data | input | 16 | Sample word |
| ref_words | input | 96 | Six reference words, oldest at the low end |
| busy | output | 1 | A matching sequence is active |
| connect | output | 1 | One-cycle splice pulse |

## Verification
Every result of this block is registered once. A command shows on `busy` one clock after the edge that samples it, and the deciding strobe shows on `connect` one clock after its edge. The bench drives each stimulus at a falling edge and samples 1 ns after the next rising edge. It checks `connect` after every single word, not only after the last one, so a pulse that comes early or late is caught. It also checks one further cycle to confirm the pulse has ended.

// File: rtl/splice_pkg.sv
package splice_pkg;

    typedef enum logic [1:0] {
        MODE_STOP   = 2'b00,
        MODE_DIRECT = 2'b01,
        MODE_TWO    = 2'b10,
        MODE_THREE  = 2'b11
    } splice_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PREP,
        ST_ALIGN,
        ST_COMPARE,
        ST_DIRECT
    } splice_state_e;

endpackage

// File: rtl/sm_window.sv
// Sliding window of the most recent words, oldest at the low end.
module sm_window #(
    parameter int WORD_W = 16,
    parameter int DEPTH  = 6
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      clear,
    input  logic                      shift,
    input  logic [WORD_W-1:0]         din,
    output logic [DEPTH*WORD_W-1:0]   view,
    output logic                      full_next
);
    localparam int FILL_W = $clog2(DEPTH + 1);
    localparam int TOTAL  = DEPTH * WORD_W;

    typedef struct packed {
        logic [TOTAL-1:0]  words;
        logic [FILL_W-1:0] fill;
    } win_t;

    win_t win_d, win_q;

    always_comb begin
        // contents after accepting din: newest enters at the top
        view      = {din, win_q.words[TOTAL-1:WORD_W]};
        full_next = (win_q.fill >= FILL_W'(DEPTH - 1));
        win_d     = win_q;
        if (clear) begin
            win_d.fill = '0;
        end else if (shift) begin
            win_d.words = view;
            if (win_q.fill != FILL_W'(DEPTH))
                win_d.fill = win_q.fill + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) win_q <= '0;
        else        win_q <= win_d;
    end

endmodule

// File: rtl/sm_pair_cmp.sv
// Per-pair equality of a candidate window against the reference words.
module sm_pair_cmp #(
    parameter int WORD_W   = 16,
    parameter int PAIRS    = 3,
    parameter int LOW_BITS = 4
) (
    input  logic [2*PAIRS*WORD_W-1:0] cand,
    input  logic [2*PAIRS*WORD_W-1:0] refw,
    input  logic                      cmp12,
    output logic [PAIRS-1:0]          pair_ok
);
    localparam logic [WORD_W-1:0] LOW_MASK = WORD_W'((1 << LOW_BITS) - 1);

    logic [WORD_W-1:0] mask;
    assign mask = cmp12 ? ~LOW_MASK : {WORD_W{1'b1}};

    for (genvar k = 0; k < PAIRS; k++) begin : g_pair
        logic [WORD_W-1:0] c_l, c_r, r_l, r_r;
        assign c_l = cand[(2*k)*WORD_W   +: WORD_W];
        assign c_r = cand[(2*k+1)*WORD_W +: WORD_W];
        assign r_l = refw[(2*k)*WORD_W   +: WORD_W];
        assign r_r = refw[(2*k+1)*WORD_W +: WORD_W];
        assign pair_ok[k] = ((c_l & mask) == (r_l & mask)) &&
                            ((c_r & mask) == (r_r & mask));
    end

endmodule

// File: rtl/sm_ctrl.sv
// Sequencing of preparation, alignment, comparison and direct connect.
module sm_ctrl
    import splice_pkg::*;
#(
    parameter int PAIRS        = 3,
    parameter int PREP_WORDS   = 5,
    parameter int DIRECT_WORDS = 3,
    parameter int QUORUM       = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [1:0]       cmd_mode,
    input  logic             smp_valid,
    input  logic             smp_right,
    input  logic [PAIRS-1:0] pair_ok,
    input  logic             full_next,
    output logic             win_clear,
    output logic             win_shift,
    output logic             busy,
    output logic             connect
);
    localparam int CNT_MAX = (PREP_WORDS > DIRECT_WORDS) ? PREP_WORDS : DIRECT_WORDS;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    typedef struct packed {
        splice_state_e    state;
        logic             two_of_three;
        logic [CNT_W-1:0] cnt;
        logic             primed;
        logic             connect;
    } ctrl_t;

    ctrl_t c_d, c_q;
    logic  hit;
    splice_mode_e mode;

    assign mode = splice_mode_e'(cmd_mode);

    always_comb begin
        hit = c_q.two_of_three ? ($countones(pair_ok) >= QUORUM) : (&pair_ok);
        c_d         = c_q;
        c_d.connect = 1'b0;
        win_clear   = 1'b0;
        win_shift   = 1'b0;
        if (cmd_valid) begin
            case (mode)
                MODE_STOP: begin
                    c_d.state = ST_IDLE;
                end
                MODE_DIRECT: begin
                    c_d.state = ST_DIRECT;
                    c_d.cnt   = '0;
                end
                default: begin
                    c_d.two_of_three = (mode == MODE_TWO);
                    c_d.cnt          = '0;
                    win_clear        = 1'b1;
                    c_d.state        = c_q.primed ? ST_ALIGN : ST_PREP;
                end
            endcase
        end else if (smp_valid) begin
            case (c_q.state)
                ST_PREP: begin
                    if (c_q.cnt == CNT_W'(PREP_WORDS - 1)) begin
                        c_d.state  = ST_ALIGN;
                        c_d.primed = 1'b1;
                        c_d.cnt    = '0;
                    end else begin
                        c_d.cnt = c_q.cnt + 1'b1;
                    end
                end
                ST_ALIGN: begin
                    if (!smp_right) begin
                        win_shift = 1'b1;
                        c_d.state = ST_COMPARE;
                    end
                end
                ST_COMPARE: begin
                    win_shift = 1'b1;
                    if (smp_right && full_next && hit) begin
                        c_d.connect = 1'b1;
                        c_d.state   = ST_IDLE;
                    end
                end
                ST_DIRECT: begin
                    if (c_q.cnt == CNT_W'(DIRECT_WORDS - 1)) begin
                        c_d.connect = 1'b1;
                        c_d.state   = ST_IDLE;
                    end else begin
                        c_d.cnt = c_q.cnt + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q.state        <= ST_IDLE;
            c_q.two_of_three <= 1'b0;
            c_q.cnt          <= '0;
            c_q.primed       <= 1'b0;
            c_q.connect      <= 1'b0;
        end else begin
            c_q <= c_d;
        end
    end

    assign busy    = (c_q.state != ST_IDLE);
    assign connect = c_q.connect;

endmodule

// File: rtl/splice_matcher.sv
module splice_matcher #(
    parameter int WORD_W       = 16,
    parameter int PAIRS        = 3,
    parameter int LOW_BITS     = 4,
    parameter int PREP_WORDS   = 5,
    parameter int DIRECT_WORDS = 3,
    parameter int QUORUM       = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cmd_valid,
    input  logic [1:0]                  cmd_mode,
    input  logic                        cmp12,
    input  logic                        smp_valid,
    input  logic                        smp_right,
    input  logic [WORD_W-1:0]           smp_data,
    input  logic [2*PAIRS*WORD_W-1:0]   ref_words,
    output logic                        busy,
    output logic                        connect
);
    localparam int DEPTH = 2 * PAIRS;

    logic [DEPTH*WORD_W-1:0] view;
    logic                    full_next;
    logic                    win_clear;
    logic                    win_shift;
    logic [PAIRS-1:0]        pair_ok;

    sm_window #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_window (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (win_clear),
        .shift     (win_shift),
        .din       (smp_data),
        .view      (view),
        .full_next (full_next)
    );

    sm_pair_cmp #(.WORD_W(WORD_W), .PAIRS(PAIRS), .LOW_BITS(LOW_BITS)) u_cmp (
        .cand    (view),
        .refw    (ref_words),
        .cmp12   (cmp12),
        .pair_ok (pair_ok)
    );

    sm_ctrl #(
        .PAIRS(PAIRS), .PREP_WORDS(PREP_WORDS),
        .DIRECT_WORDS(DIRECT_WORDS), .QUORUM(QUORUM)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_mode  (cmd_mode),
        .smp_valid (smp_valid),
        .smp_right (smp_right),
        .pair_ok   (pair_ok),
        .full_next (full_next),
        .win_clear (win_clear),
        .win_shift (win_shift),
        .busy      (busy),
        .connect   (connect)
    );

endmodule

// File: rtl/splice_matcher_chk.sv
module splice_matcher_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_valid,
    input logic [1:0] cmd_mode,
    input logic       smp_valid,
    input logic       busy,
    input logic       connect
);
    AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_mode != 2'b00) |=> busy); // R2
    AST_STOP_CLEARS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_mode == 2'b00) |=> (!busy && !connect)); // R2
    AST_CONNECT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        connect |=> !connect); // R10
    AST_CONNECT_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        connect |-> !busy); // R10
    AST_CONNECT_FROM_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        connect |-> ($past(smp_valid) && $past(busy) && !$past(cmd_valid))); // R10
endmodule

bind splice_matcher splice_matcher_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_mode  (cmd_mode),
    .smp_valid (smp_valid),
    .busy      (busy),
    .connect   (connect)
);

// File: tb/splice_matcher_tb.sv
module splice_matcher_tb;
    logic        clk = 1'b0;
    logic        rst_n, cmd_valid, cmp12, smp_valid, smp_right;
    logic [1:0]  cmd_mode;
    logic [15:0] smp_data;
    logic [95:0] ref_words;
    logic        busy, connect;
    int          checks = 0, errors = 0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    splice_matcher u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_mode(cmd_mode),
        .cmp12(cmp12), .smp_valid(smp_valid), .smp_right(smp_right),
        .smp_data(smp_data), .ref_words(ref_words), .busy(busy), .connect(connect)
    );

    function automatic logic [15:0] refw(input int i);
        return 16'((32'h2A50 ^ (i * 32'h1103)) & 32'hFFFF);
    endfunction

    task automatic check(input string req, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%0b exp=%0b at %0t", req, got, exp, $time);
        end
    endtask

    task automatic word(input logic r, input logic [15:0] d, output logic c, output logic b);
        @(negedge clk);
        smp_valid = 1'b1; smp_right = r; smp_data = d;
        @(posedge clk); #1;
        c = connect; b = busy;
        @(negedge clk);
        smp_valid = 1'b0;
    endtask

    task automatic command(input logic [1:0] m, output logic b);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_mode = m;
        @(posedge clk); #1;
        b = busy;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic run_pairs(input logic [2:0] bad, input logic [15:0] flip,
                             input logic exp_last, input string req);
        logic c, b;
        for (int k = 0; k < 3; k++) begin
            for (int ch = 0; ch < 2; ch++) begin
                word(ch[0], refw(2*k+ch) ^ (bad[k] ? flip : 16'h0000), c, b);
                check(req, c, (k == 2 && ch == 1) ? exp_last : 1'b0);
            end
        end
        @(posedge clk); #1;
        check({req, " pulse ended (R10)"}, connect, 1'b0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic c, b, exp;
        rst_n = 1'b0; cmd_valid = 1'b0; cmd_mode = 2'b00; cmp12 = 1'b0;
        smp_valid = 1'b0; smp_right = 1'b0; smp_data = '0;
        for (int i = 0; i < 6; i++) ref_words[16*i +: 16] = refw(i);
        repeat (3) @(posedge clk); #1;
        check("R1 busy", busy, 1'b0);
        check("R1 connect", connect, 1'b0);
        @(negedge clk); rst_n = 1'b1;

        // R2: stop while idle has no effect
        command(2'b00, b);
        check("R2 stop idle busy", b, 1'b0);
        check("R2 stop idle connect", connect, 1'b0);

        // R3: first start consumes 5 words; the next R is ignored by alignment
        command(2'b11, b);
        check("R2 start busy", b, 1'b1);
        run_pairs(3'b000, 16'h8000, 1'b0, "R3 prep words unused");
        run_pairs(3'b000, 16'h8000, 1'b1, "R3 match after prep");
        check("R10 busy low at connect", busy, 1'b0);

        // R3: restart skips preparation
        command(2'b11, b);
        run_pairs(3'b000, 16'h8000, 1'b1, "R3 restart skips prep");

        // R4: leading right word ignored
        command(2'b11, b);
        word(1'b1, 16'h0BAD, c, b);
        check("R4 leading right ignored", c, 1'b0);
        run_pairs(3'b000, 16'h8000, 1'b1, "R4 aligned on left");

        // R5/R6/R7 sweep of mismatch patterns
        for (int m = 0; m < 2; m++) begin
            for (int p = 0; p < 8; p++) begin
                logic [2:0] pat;
                pat = 3'(p);
                command(m == 0 ? 2'b11 : 2'b10, b);
                exp = (m == 0) ? (pat == 3'b000) : ($countones(pat) <= 1);
                run_pairs(pat, 16'h8000, exp, m == 0 ? "R5 all pairs" : "R6 two of three");
                if (!exp) run_pairs(3'b000, 16'h8000, 1'b1, "R7 slide then match");
            end
        end

        // R9: low nibble ignored only with cmp12
        cmp12 = 1'b1;
        command(2'b11, b);
        run_pairs(3'b111, 16'h000F, 1'b1, "R9 low nibble masked");
        command(2'b11, b);
        run_pairs(3'b111, 16'h0010, 1'b0, "R9 bit4 still compared");
        run_pairs(3'b000, 16'h0000, 1'b1, "R9 recover");
        cmp12 = 1'b0;
        command(2'b11, b);
        run_pairs(3'b111, 16'h000F, 1'b0, "R9 full compare");
        run_pairs(3'b000, 16'h0000, 1'b1, "R9 recover full");
        command(2'b11, b);
        for (int k = 0; k < 3; k++) begin
            for (int ch = 0; ch < 2; ch++) begin
                if (k == 2 && ch == 1) cmp12 = 1'b1;
                word(ch[0], refw(2*k+ch) ^ 16'h0005, c, b);
                check("R9 mid-sequence switch", c, (k == 2 && ch == 1));
            end
        end
        cmp12 = 1'b0;

        // R8: direct connect on third word
        command(2'b01, b);
        check("R8 direct busy", b, 1'b1);
        word(1'b0, 16'h1111, c, b); check("R8 word1", c, 1'b0);
        word(1'b1, 16'h2222, c, b); check("R8 word2", c, 1'b0);
        word(1'b0, 16'h3333, c, b); check("R8 word3 connect", c, 1'b1);
        check("R8 busy cleared", b, 1'b0);

        // R2: stop ends an active sequence
        command(2'b11, b);
        word(1'b0, refw(0), c, b);
        word(1'b1, refw(1), c, b);
        command(2'b00, b);
        check("R2 stop active busy", b, 1'b0);
        run_pairs(3'b000, 16'h8000, 1'b0, "R2 no connect after stop");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule